// File: doc/BRIEF.md
# Windowed Memory Bank Controller

This block lets an 8-bit microcontroller with 16-bit address spaces reach a 31-bit physical memory through 32 KiB windows. Three bank selectors, each 16 bits wide, decide which physical 32 KiB page each window shows. Two selectors cover program space: one for addresses below 0x8000 and one for addresses from 0x8000 up. The third covers a read-write window in the lower half of external data space. Each selector is stored as two byte registers in external data space. The CPU writes them and can read them back.

The physical address is the selected page number followed by the 15-bit offset inside the window. A region decoder classifies the result as ROM, RAM or unmapped. It drives the backing-memory strobes and protects ROM against writes through the data window. Any other external data access at 0x8000 or above goes out on a pass-through port for the surrounding peripherals.

Top module: `bank_window_ctrl`

## Requirements
- R1: After reset all six selector bytes read back as 0x00, so every window starts at physical address 0.
- R2: Selector bytes sit in external data space at 0xFC06..0xFC0B. 0xFC06/0xFC07 serve the lower program window, 0xFC08/0xFC09 the upper program window and 0xFC0A/0xFC0B the data window. The lower address of each pair holds the high byte. A read returns the last value written, and `xd_sel_hit` is 1 during any access to these six addresses.
- R3: The physical address equals selector × 0x8000 plus address bits [14:0], giving 31 bits.
- R4: A program read uses the lower selector when `prog_addr[15]` is 0 and the upper selector when it is 1. Program space has no write path.
- R5: An external data access with `xd_addr[15]` = 0 is translated through the data-window selector and may read or write.
- R6: Physical 0x000000–0x3FFFFF is ROM (`mem_rom_sel`) and 0x400000–0x7FFFFF is RAM (`mem_ram_sel`). A window write drives `mem_wr` only for RAM. A write that lands in ROM produces no strobe.
- R7: A physical address above 0x7FFFFF raises no memory strobe. Reads from it return 0xFF and writes to it are dropped.
- R8: Translation is combinational. A selector write takes effect from the cycle after the rising edge that stores it, and an access in the same cycle as the write still uses the old value.
- R9: When a program read and a data-window access occur in the same cycle, the program read owns the memory port. The data read returns 0xFF and the data write is dropped.
- R10: An external data access at 0x8000 or above outside 0xFC06..0xFC0B goes to the pass-through port (`pt_rd`/`pt_wr`, address and write data copied). `xd_sel_hit` is 0 for such an access, and its read data is `pt_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_rd | input | 1 | Program space read |
| prog_addr | input | 16 | Program address |
| prog_rdata | output | 8 | Program read data |
| xd_rd | input | 1 | External data read |
| xd_wr | input | 1 | External data write |
| xd_addr | input | 16 | External data address |
| xd_wdata | input | 8 | External data write data |
| xd_rdata | output | 8 | External data read data |
| xd_sel_hit | output | 1 | Access targets a selector byte |
| pt_rd | output | 1 | Pass-through read strobe |
| pt_wr | output | 1 | Pass-through write strobe |
| pt_addr | output | 16 | Pass-through address |
| pt_wdata | output | 8 | Pass-through write data |
| pt_rdata | input | 8 | Pass-through read data |
| mem_rd | output | 1 | Backing memory read strobe |
| mem_wr | output | 1 | Backing memory write strobe |
| mem_addr | output | 31 | Physical address |
| mem_wdata | output | 8 | Backing memory write data |
| mem_rdata | input | 8 | Backing memory read data |
| mem_rom_sel | output | 1 | Strobed access is in ROM |
| mem_ram_sel | output | 1 | Strobed access is in RAM |

## Verification
Every translated address, strobe and read datum is combinational, so it is due in the same cycle as the access. The bench drives inputs on the falling edge and samples 1 ns later, well before the next rising edge. Selector writes are the only registered result. They are checked twice: first in the cycle of the write, where the old page must still show, and then after the following rising edge, where the new page must show. The memory model in the bench returns a value computed from the address, so read data also shows which physical address was used.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    typedef enum logic [1:0] {
        RGN_ROM  = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_VOID = 2'd2
    } rgn_e;

    typedef enum logic [1:0] {
        WIN_LO = 2'd0,
        WIN_HI = 2'd1,
        WIN_XD = 2'd2
    } win_e;

    localparam int NUM_WIN = 3;
    localparam logic [7:0] OPEN_BUS = 8'hFF;

endpackage

// File: rtl/bwc_sel_file.sv
module bwc_sel_file #(
    parameter int AW    = 16,
    parameter int SELW  = 16,
    parameter int NWIN  = 3,
    parameter logic [AW-1:0] BASE = 16'hFC06
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              addr,
    input  logic [7:0]                 wdata,
    output logic [NWIN-1:0][SELW-1:0]  sel_o,
    output logic                       hit,
    output logic [7:0]                 rdata
);
    localparam int NB     = SELW / 8;
    localparam int NBYTES = NWIN * NB;

    logic [7:0] bytes_q [NBYTES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NBYTES; i++) begin
            if (rst)
                bytes_q[i] <= 8'h00;
            else if (wr_en && addr == BASE + AW'(i))
                bytes_q[i] <= wdata;
        end
    end

    always_comb begin
        hit   = 1'b0;
        rdata = 8'h00;
        for (int i = 0; i < NBYTES; i++) begin
            if (addr == BASE + AW'(i)) begin
                hit   = 1'b1;
                rdata = bytes_q[i];
            end
        end
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        for (genvar b = 0; b < NB; b++) begin : g_byte
            localparam int IDX = w * NB + b;
            localparam logic [AW-1:0] ADR = BASE + AW'(IDX);
            assign sel_o[w][SELW-1-8*b -: 8] = bytes_q[IDX];

            AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
                (wr_en && addr == ADR) |=> bytes_q[IDX] == $past(wdata)); // R2
            AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
                !(wr_en && addr == ADR) |=> $stable(bytes_q[IDX])); // R8
        end
    end

endmodule

// File: rtl/bwc_map.sv
module bwc_map
    import bwc_pkg::*;
#(
    parameter int AW       = 16,
    parameter int SELW     = 16,
    parameter int ROM_LOG2 = 22,
    parameter int RAM_LOG2 = 22,
    localparam int PW      = SELW + AW - 1
) (
    input  logic [SELW-1:0] sel,
    input  logic [AW-2:0]   off,
    output logic [PW-1:0]   phys,
    output rgn_e            rgn
);
    localparam logic [PW-1:0] ONE     = PW'(1);
    localparam logic [PW-1:0] ROM_LIM = ONE << ROM_LOG2;
    localparam logic [PW-1:0] RAM_LIM = ROM_LIM + (ONE << RAM_LOG2);

    assign phys = {sel, off};

    always_comb begin
        if (phys < ROM_LIM)
            rgn = RGN_ROM;
        else if (phys < RAM_LIM)
            rgn = RGN_RAM;
        else
            rgn = RGN_VOID;
    end

endmodule

// File: rtl/bank_window_ctrl.sv
module bank_window_ctrl
    import bwc_pkg::*;
#(
    parameter int AW       = 16,
    parameter int SELW     = 16,
    parameter int ROM_LOG2 = 22,
    parameter int RAM_LOG2 = 22,
    parameter logic [AW-1:0] SEL_BASE = 16'hFC06,
    localparam int PW      = SELW + AW - 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           prog_rd,
    input  logic [AW-1:0]  prog_addr,
    output logic [7:0]     prog_rdata,
    input  logic           xd_rd,
    input  logic           xd_wr,
    input  logic [AW-1:0]  xd_addr,
    input  logic [7:0]     xd_wdata,
    output logic [7:0]     xd_rdata,
    output logic           xd_sel_hit,
    output logic           pt_rd,
    output logic           pt_wr,
    output logic [AW-1:0]  pt_addr,
    output logic [7:0]     pt_wdata,
    input  logic [7:0]     pt_rdata,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic [PW-1:0]  mem_addr,
    output logic [7:0]     mem_wdata,
    input  logic [7:0]     mem_rdata,
    output logic           mem_rom_sel,
    output logic           mem_ram_sel
);
    logic [NUM_WIN-1:0][SELW-1:0] sel;
    logic                         reg_hit;
    logic [7:0]                   reg_rdata;
    logic                         xd_any, xd_win, dwin_go;
    logic [SELW-1:0]              prog_sel;
    logic [PW-1:0]                p_phys, d_phys;
    rgn_e                         p_rgn, d_rgn, cur_rgn;

    assign xd_any = xd_rd | xd_wr;
    assign xd_win = ~xd_addr[AW-1];

    bwc_sel_file #(.AW(AW), .SELW(SELW), .NWIN(NUM_WIN), .BASE(SEL_BASE)) u_sel (
        .clk   (clk),
        .rst   (rst),
        .wr_en (xd_wr & ~xd_win),
        .addr  (xd_addr),
        .wdata (xd_wdata),
        .sel_o (sel),
        .hit   (reg_hit),
        .rdata (reg_rdata)
    );

    assign prog_sel = prog_addr[AW-1] ? sel[WIN_HI] : sel[WIN_LO];

    bwc_map #(.AW(AW), .SELW(SELW), .ROM_LOG2(ROM_LOG2), .RAM_LOG2(RAM_LOG2)) u_pmap (
        .sel  (prog_sel),
        .off  (prog_addr[AW-2:0]),
        .phys (p_phys),
        .rgn  (p_rgn)
    );

    bwc_map #(.AW(AW), .SELW(SELW), .ROM_LOG2(ROM_LOG2), .RAM_LOG2(RAM_LOG2)) u_dmap (
        .sel  (sel[WIN_XD]),
        .off  (xd_addr[AW-2:0]),
        .phys (d_phys),
        .rgn  (d_rgn)
    );

    // program fetch owns the memory port when both sides want it
    assign dwin_go = xd_any & xd_win & ~prog_rd;

    always_comb begin
        mem_rd   = (prog_rd && p_rgn != RGN_VOID) || (dwin_go && xd_rd && d_rgn != RGN_VOID);
        mem_wr   = dwin_go && xd_wr && d_rgn == RGN_RAM;
        mem_addr = prog_rd ? p_phys : d_phys;
        cur_rgn  = prog_rd ? p_rgn : d_rgn;
        mem_rom_sel = (mem_rd || mem_wr) && cur_rgn == RGN_ROM;
        mem_ram_sel = (mem_rd || mem_wr) && cur_rgn == RGN_RAM;
    end

    assign mem_wdata = xd_wdata;

    assign prog_rdata = (p_rgn != RGN_VOID) ? mem_rdata : OPEN_BUS;

    assign xd_sel_hit = xd_any & ~xd_win & reg_hit;
    assign pt_rd      = xd_rd & ~xd_win & ~reg_hit;
    assign pt_wr      = xd_wr & ~xd_win & ~reg_hit;
    assign pt_addr    = xd_addr;
    assign pt_wdata   = xd_wdata;

    always_comb begin
        if (xd_win)
            xd_rdata = (dwin_go && d_rgn != RGN_VOID) ? mem_rdata : OPEN_BUS;
        else if (reg_hit)
            xd_rdata = reg_rdata;
        else
            xd_rdata = pt_rdata;
    end

    AST_ROM_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_ram_sel && !mem_rom_sel)); // R6
    AST_VOID_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> (mem_rom_sel || mem_ram_sel)); // R7
    AST_FETCH_WINS: assert property (@(posedge clk) disable iff (rst)
        (prog_rd && xd_any && xd_win) |-> (!mem_wr && mem_addr == p_phys)); // R9
    AST_PT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (pt_rd || pt_wr) |-> (!xd_sel_hit && xd_addr[AW-1] && !(dwin_go && mem_wr))); // R10

endmodule

// File: tb/tb_bank_window_ctrl.sv
module tb_bank_window_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_rd = 1'b0;
    logic [15:0] prog_addr = '0;
    logic [7:0]  prog_rdata;
    logic        xd_rd = 1'b0, xd_wr = 1'b0;
    logic [15:0] xd_addr = '0;
    logic [7:0]  xd_wdata = '0;
    logic [7:0]  xd_rdata;
    logic        xd_sel_hit;
    logic        pt_rd, pt_wr;
    logic [15:0] pt_addr;
    logic [7:0]  pt_wdata;
    logic [7:0]  pt_rdata = 8'h77;
    logic        mem_rd, mem_wr;
    logic [30:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_rom_sel, mem_ram_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mdl(input logic [30:0] a);
        return a[7:0] ^ a[22:15] ^ 8'h5A;
    endfunction

    assign mem_rdata = mdl(mem_addr);

    bank_window_ctrl dut (
        .clk(clk), .rst(rst),
        .prog_rd(prog_rd), .prog_addr(prog_addr), .prog_rdata(prog_rdata),
        .xd_rd(xd_rd), .xd_wr(xd_wr), .xd_addr(xd_addr), .xd_wdata(xd_wdata),
        .xd_rdata(xd_rdata), .xd_sel_hit(xd_sel_hit),
        .pt_rd(pt_rd), .pt_wr(pt_wr), .pt_addr(pt_addr), .pt_wdata(pt_wdata),
        .pt_rdata(pt_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rom_sel(mem_rom_sel), .mem_ram_sel(mem_ram_sel)
    );

    typedef struct packed {
        logic [1:0]  win;
        logic [15:0] sel;
        logic [15:0] addr;
        logic [30:0] phys;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 16'h0001, 16'h1234, 31'h0000_9234},
        '{2'd1, 16'h0005, 16'h8010, 31'h0002_8010},
        '{2'd2, 16'h0080, 16'h0100, 31'h0040_0100},
        '{2'd0, 16'h007F, 16'h7FFF, 31'h003F_FFFF},
        '{2'd1, 16'h00FF, 16'hFFFF, 31'h007F_FFFF},
        '{2'd2, 16'h0100, 16'h0000, 31'h0080_0000},
        '{2'd0, 16'hFFFF, 16'h7FFF, 31'h7FFF_FFFF},
        '{2'd2, 16'hA5C3, 16'h2AAA, 31'h52E1_AAAA}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        prog_rd = 1'b0; xd_rd = 1'b0; xd_wr = 1'b0;
    endtask

    task automatic xwr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        xd_wr = 1'b1; xd_addr = a; xd_wdata = d;
        @(negedge clk);
        xd_wr = 1'b0;
    endtask

    task automatic set_sel(input int w, input logic [15:0] v);
        xwr(16'hFC06 + 16'(2 * w), v[15:8]);
        xwr(16'hFC07 + 16'(2 * w), v[7:0]);
    endtask

    task automatic rd_reg(input string req, input logic [15:0] a, input logic [7:0] e);
        @(negedge clk);
        xd_rd = 1'b1; xd_addr = a;
        #1;
        chk(req, {24'h0, xd_rdata}, {24'h0, e});
        chk(req, {31'h0, xd_sel_hit}, 32'h1);
        xd_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < 6; i++) rd_reg("R1", 16'hFC06 + 16'(i), 8'h00);
        @(negedge clk);
        prog_rd = 1'b1; prog_addr = 16'h8000;
        #1;
        chk("R1", {1'b0, mem_addr}, 32'h0);
        chk("R1", {31'h0, mem_rom_sel}, 32'h1);
        idle();

        // R3/R4/R5/R6/R7: vector table
        for (int v = 0; v < NV; v++) begin
            logic mapped;
            set_sel(int'(VEC[v].win), VEC[v].sel);
            mapped = VEC[v].phys < 31'h0080_0000;
            @(negedge clk);
            if (VEC[v].win < 2'd2) begin
                prog_rd = 1'b1; prog_addr = VEC[v].addr;
            end else begin
                xd_rd = 1'b1; xd_addr = VEC[v].addr;
            end
            #1;
            chk("R3 R4 R5 address", {1'b0, mem_addr}, {1'b0, VEC[v].phys});
            chk("R7 strobe", {31'h0, mem_rd}, {31'h0, mapped});
            chk("R6 rom", {31'h0, mem_rom_sel}, {31'h0, VEC[v].phys < 31'h0040_0000});
            chk("R6 ram", {31'h0, mem_ram_sel},
                {31'h0, mapped && VEC[v].phys >= 31'h0040_0000});
            chk("R7 data", {24'h0, (VEC[v].win < 2'd2) ? prog_rdata : xd_rdata},
                {24'h0, mapped ? mdl(VEC[v].phys) : 8'hFF});
            idle();
        end

        // R2: readback of the last values, high byte first
        rd_reg("R2", 16'hFC06, 8'hFF);
        rd_reg("R2", 16'hFC07, 8'hFF);
        rd_reg("R2", 16'hFC08, 8'h00);
        rd_reg("R2", 16'hFC09, 8'hFF);
        rd_reg("R2", 16'hFC0A, 8'hA5);
        rd_reg("R2", 16'hFC0B, 8'hC3);

        // R8: write takes effect after the edge
        set_sel(0, 16'h0001);
        @(negedge clk);
        xd_wr = 1'b1; xd_addr = 16'hFC07; xd_wdata = 8'h02;
        prog_rd = 1'b1; prog_addr = 16'h0000;
        #1;
        chk("R8 old", {1'b0, mem_addr}, 32'h0000_8000);
        chk("R2 hit", {31'h0, xd_sel_hit}, 32'h1);
        @(negedge clk);
        xd_wr = 1'b0;
        #1;
        chk("R8 new", {1'b0, mem_addr}, 32'h0001_0000);
        idle();

        // R6: RAM write goes out, ROM write dropped
        set_sel(2, 16'h0080);
        @(negedge clk);
        xd_wr = 1'b1; xd_addr = 16'h0004; xd_wdata = 8'h3C;
        #1;
        chk("R6 ram wr", {31'h0, mem_wr}, 32'h1);
        chk("R6 ram addr", {1'b0, mem_addr}, 32'h0040_0004);
        chk("R6 wdata", {24'h0, mem_wdata}, 32'h3C);
        chk("R6 ram sel", {31'h0, mem_ram_sel}, 32'h1);
        idle();
        set_sel(2, 16'h0001);
        @(negedge clk);
        xd_wr = 1'b1; xd_addr = 16'h0004; xd_wdata = 8'h3C;
        #1;
        chk("R6 rom wr dropped", {31'h0, mem_wr}, 32'h0);
        chk("R6 rom no sel", {31'h0, mem_rom_sel | mem_ram_sel}, 32'h0);
        idle();

        // R7: write to unmapped dropped
        set_sel(2, 16'h0100);
        @(negedge clk);
        xd_wr = 1'b1; xd_addr = 16'h0004;
        #1;
        chk("R7 void wr", {31'h0, mem_wr}, 32'h0);
        idle();

        // R9: fetch priority
        set_sel(2, 16'h0080);
        @(negedge clk);
        prog_rd = 1'b1; prog_addr = 16'h0010;
        xd_rd = 1'b1; xd_addr = 16'h0004;
        #1;
        chk("R9 addr", {1'b0, mem_addr}, 32'h0001_0010);
        chk("R9 prog data", {24'h0, prog_rdata}, {24'h0, mdl(31'h0001_0010)});
        chk("R9 data ff", {24'h0, xd_rdata}, 32'hFF);
        xd_rd = 1'b0; xd_wr = 1'b1;
        #1;
        chk("R9 wr dropped", {31'h0, mem_wr}, 32'h0);
        idle();

        // R10: pass-through
        @(negedge clk);
        xd_rd = 1'b1; xd_addr = 16'hFF80;
        #1;
        chk("R10 pt_rd", {31'h0, pt_rd}, 32'h1);
        chk("R10 hit", {31'h0, xd_sel_hit}, 32'h0);
        chk("R10 data", {24'h0, xd_rdata}, 32'h77);
        chk("R10 addr", {16'h0, pt_addr}, 32'hFF80);
        chk("R10 no mem", {31'h0, mem_rd}, 32'h0);
        xd_addr = 16'hFC05;
        #1;
        chk("R10 below", {31'h0, pt_rd}, 32'h1);
        idle();
        @(negedge clk);
        xd_wr = 1'b1; xd_addr = 16'hFC0C; xd_wdata = 8'h09;
        #1;
        chk("R10 pt_wr", {31'h0, pt_wr}, 32'h1);
        chk("R10 wdata", {24'h0, pt_wdata}, 32'h09);
        chk("R10 hit above", {31'h0, xd_sel_hit}, 32'h0);
        @(negedge clk);
        xd_wr = 1'b0;
        rd_reg("R10 no reg change", 16'hFC0B, 8'h80);
        rd_reg("R10 no reg change", 16'hFC0A, 8'h00);

        // R1: reset mid-run clears selectors
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_reg("R1 rerun", 16'hFC06, 8'h00);
        rd_reg("R1 rerun", 16'hFC0B, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule